// File: doc/BRIEF.md
# Nested Vectored Interrupt Arbiter

This block sits beside a small processor core and decides which exception the core should take next. It gathers 32 peripheral request lines and a handful of system exceptions into one pending vector. Each peripheral line has its own three-way source selector, which picks a fixed-function line, a DMA channel interrupt or a general routed signal. The block applies per-line enables and programmable priorities, then picks a single winner. The lowest effective priority value wins, and a tie goes to the lower exception number.

Not every winner may run at once. The priority value is split into a preempt part and a subpriority part at a programmable point. A winner is offered to the core only when its preempt level is strictly more urgent than the level of the exception now running. The offer is a request flag with the exception number and the vector table address. The core acknowledges an offer to enter that exception and pulses a return input when it leaves. A stack of suspended levels makes sure each return restores the level that was running before.

Top module: `vint_arbiter`

## Requirements
- R1: Peripheral line k is exception number 16+k, and the presented address `irq_addr` always equals four times `irq_exc` (line 31 gives exception 47 and address 188).
- R2: The source code of peripheral line k (write kind 2 at index 16+k, `cfg_wdata[1:0]`: 0 fixed-function, 1 DMA, 2 routed, 3 none, reset value 0) decides which of `src_fixed[k]`, `src_dma[k]`, `src_route[k]` can make the line pending. The other inputs have no effect.
- R3: Pending state is sticky. A one-cycle request pulse keeps the exception pending until it is acknowledged, and the acknowledge clears it. A request present in the acknowledge cycle keeps it pending.
- R4: Peripheral enables (write kind 0 at index 16+k, `cfg_wdata[0]`, reset 0) gate arbitration only. A disabled line that is pending is not offered, and it is offered once it is enabled.
- R5: `sys_req[2]` (exception 2) and `sys_req[3]` (exception 3) have fixed levels above every programmable priority, with exception 2 above exception 3. The system exceptions 4, 5, 6, 11, 12, 14 and 15 are always enabled and take programmable priorities.
- R6: Among enabled pending exceptions, the lowest full priority value wins, and equal values go to the lower exception number.
- R7: The grouping value G (write kind 3, `cfg_wdata`, saturated to the priority width) makes the preempt level equal to the priority shifted right by G. Only the preempt level is compared with the running level, and the full value still orders pending exceptions.
- R8: A priority write (write kind 1 at the exception index, low priority-width bits of `cfg_wdata`) is used by the arbitration in the very next cycle. The presented result reflects it at the second clock edge after the write is driven.
- R9: `sys_req` bits 0, 1, 7, 8, 9, 10 and 13 are ignored, and no reserved exception number is ever presented.
- R10: `irq_req` is high only when the winner's preempt level is strictly more urgent than the running level. An acknowledge saves the running level and makes the acknowledged level the running one. `cpu_ret` restores the saved level, and a return with nothing saved has no effect.
- R11: An acknowledge while `irq_req` is high clears `irq_req` at that same edge. Arbitration resumes at the next edge.
- R12: After reset nothing is pending, nothing is running, `irq_req` is low and `irq_exc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_fixed | input | N_IRQ | Fixed-function request per peripheral line |
| src_dma | input | N_IRQ | DMA channel request per peripheral line |
| src_route | input | N_IRQ | Routed digital request per peripheral line |
| sys_req | input | 16 | System exception requests, bit n is exception n |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write kind: 0 enable, 1 priority, 2 source, 3 grouping |
| cfg_idx | input | EXC_W | Exception number addressed by the write |
| cfg_wdata | input | 8 | Write data |
| irq_req | output | 1 | An exception is offered to the core |
| irq_exc | output | EXC_W | Offered exception number |
| irq_addr | output | EXC_W+2 | Offered vector table address |
| cpu_ack | input | 1 | Core takes the offered exception; if it coincides with an accepted acknowledge, `cpu_ret` is ignored |
| cpu_ret | input | 1 | Core returns from the running exception |

## Verification
The hardest case to reach is a pending exception that must stay blocked by the running level while its full priority still beats the others. That needs nesting at least two deep, and a grouping value that gives two lines the same preempt level but different subpriorities. The stimulus gets there by acknowledging one line, pulsing a second line that is more urgent only in its subpriority, and then stepping through returns. Each return must release exactly the exception that the restored level now allows. The same path with grouping zero shows the opposite outcome, and a late priority rewrite on a pending line checks that the new value is used on the very next arbitration.

// File: rtl/vint_pkg.sv
package vint_pkg;
  localparam int LVL_W = 10;
  localparam logic [LVL_W-1:0] LVL_IDLE = '1;
  // live system exceptions: 2,3,4,5,6,11,12,14,15
  localparam logic [15:0] SYS_LIVE = 16'hD87C;
  // programmable subset: 4,5,6,11,12,14,15
  localparam logic [15:0] SYS_PROG = 16'hD870;
  localparam int unsigned EXC_NMI  = 2;
  localparam int unsigned EXC_HARD = 3;
  localparam int unsigned EXC_IRQ0 = 16;

  typedef enum logic [1:0] {
    CFG_ENABLE = 2'd0,
    CFG_PRIO   = 2'd1,
    CFG_SOURCE = 2'd2,
    CFG_GROUP  = 2'd3
  } cfg_kind_e;

  function automatic bit is_prog(input int unsigned e);
    if (e >= EXC_IRQ0) return 1'b1;
    return SYS_PROG[e[3:0]];
  endfunction

  // fixed exceptions map below the programmable range, which starts at 3
  function automatic logic [LVL_W-1:0] level_of(input int unsigned e,
                                                input logic [7:0] prio,
                                                input int unsigned shift);
    if (e == EXC_NMI)  return LVL_W'(1);
    if (e == EXC_HARD) return LVL_W'(2);
    return LVL_W'(prio >> shift) + LVL_W'(3);
  endfunction

  function automatic logic src_pick(input logic [1:0] sel, input logic f,
                                    input logic d, input logic r);
    case (sel)
      2'd0:    return f;
      2'd1:    return d;
      2'd2:    return r;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int unsigned vec_addr(input int unsigned e);
    return e * 4;
  endfunction
endpackage

// File: rtl/vint_cfg.sv
module vint_cfg #(
  parameter int N_IRQ = 32,
  parameter int PRIO_BITS = 3,
  localparam int NEXC = 16 + N_IRQ,
  localparam int EXC_W = $clog2(NEXC)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic [1:0]                         cfg_kind,
  input  logic [EXC_W-1:0]                   cfg_idx,
  input  logic [7:0]                         cfg_wdata,
  output logic [N_IRQ-1:0]                   irq_en,
  output logic [N_IRQ-1:0][1:0]              src_sel,
  output logic [NEXC-1:0][PRIO_BITS-1:0]     prio,
  output logic [3:0]                         grp
);
  import vint_pkg::*;

  cfg_kind_e kind;
  assign kind = cfg_kind_e'(cfg_kind);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en  <= '0;
      src_sel <= '0;
      prio    <= '0;
      grp     <= '0;
    end else if (cfg_we) begin
      case (kind)
        CFG_ENABLE: begin
          for (int i = 0; i < N_IRQ; i++)
            if (cfg_idx == EXC_W'(16 + i)) irq_en[i] <= cfg_wdata[0];
        end
        CFG_SOURCE: begin
          for (int i = 0; i < N_IRQ; i++)
            if (cfg_idx == EXC_W'(16 + i)) src_sel[i] <= cfg_wdata[1:0];
        end
        CFG_PRIO: begin
          for (int e = 0; e < NEXC; e++)
            if (cfg_idx == EXC_W'(e) && is_prog(unsigned'(e)))
              prio[e] <= cfg_wdata[PRIO_BITS-1:0];
        end
        default: begin
          grp <= (cfg_wdata > 8'(PRIO_BITS)) ? 4'(PRIO_BITS) : cfg_wdata[3:0];
        end
      endcase
    end
  end
endmodule

// File: rtl/vint_pend.sv
module vint_pend #(
  parameter int N_IRQ = 32,
  localparam int NEXC = 16 + N_IRQ,
  localparam int EXC_W = $clog2(NEXC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_IRQ-1:0]      src_fixed,
  input  logic [N_IRQ-1:0]      src_dma,
  input  logic [N_IRQ-1:0]      src_route,
  input  logic [N_IRQ-1:0][1:0] src_sel,
  input  logic [15:0]           sys_req,
  input  logic                  clr_en,
  input  logic [EXC_W-1:0]      clr_idx,
  output logic [NEXC-1:0]       pend
);
  import vint_pkg::*;

  logic [NEXC-1:0] set_now;
  logic [NEXC-1:0] clr_vec;

  assign set_now[15:0] = sys_req & SYS_LIVE;

  generate
    for (genvar i = 0; i < N_IRQ; i++) begin : g_src
      assign set_now[16+i] = src_pick(src_sel[i], src_fixed[i], src_dma[i], src_route[i]);
    end
  endgenerate

  assign clr_vec = clr_en ? (NEXC'(1) << clr_idx) : '0;

  // a request in the clearing cycle wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= set_now | (pend & ~clr_vec);
  end
endmodule

// File: rtl/vint_pick.sv
module vint_pick #(
  parameter int N_IRQ = 32,
  parameter int PRIO_BITS = 3,
  localparam int NEXC = 16 + N_IRQ,
  localparam int EXC_W = $clog2(NEXC)
) (
  input  logic [NEXC-1:0]                  pend,
  input  logic [NEXC-1:0]                  en_full,
  input  logic [NEXC-1:0][PRIO_BITS-1:0]   prio,
  input  logic [3:0]                       grp,
  output logic                             win_valid,
  output logic [EXC_W-1:0]                 win_exc,
  output logic [vint_pkg::LVL_W-1:0]       win_pre
);
  import vint_pkg::*;

  always_comb begin
    logic [LVL_W-1:0] best;
    logic [LVL_W-1:0] key;
    logic             cand;
    win_valid = 1'b0;
    win_exc   = '0;
    win_pre   = LVL_IDLE;
    best      = LVL_IDLE;
    for (int e = 0; e < NEXC; e++) begin
      cand = pend[e] & en_full[e];
      key  = level_of(unsigned'(e), 8'(prio[e]), 0);
      // strict compare in ascending order keeps the lower number on ties
      if (cand && (!win_valid || key < best)) begin
        win_valid = 1'b1;
        best      = key;
        win_exc   = EXC_W'(e);
        win_pre   = level_of(unsigned'(e), 8'(prio[e]), 32'(grp));
      end
    end
  end
endmodule

// File: rtl/vint_lvl_stack.sv
module vint_lvl_stack #(
  parameter int PRIO_BITS = 3,
  localparam int DEPTH = (1 << PRIO_BITS) + 2,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic                        pop,
  input  logic [vint_pkg::LVL_W-1:0]  push_lvl,
  output logic [vint_pkg::LVL_W-1:0]  cur_lvl
);
  import vint_pkg::*;

  logic [LVL_W-1:0] saved [DEPTH];
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_lvl <= LVL_IDLE;
      ptr     <= '0;
      for (int i = 0; i < DEPTH; i++) saved[i] <= LVL_IDLE;
    end else if (push) begin
      if (ptr < PTR_W'(DEPTH)) begin
        saved[ptr] <= cur_lvl;
        ptr        <= ptr + 1'b1;
        cur_lvl    <= push_lvl;
      end
    end else if (pop && ptr != '0) begin
      cur_lvl <= saved[ptr - 1'b1];
      ptr     <= ptr - 1'b1;
    end
  end
endmodule

// File: rtl/vint_arbiter.sv
module vint_arbiter #(
  parameter int N_IRQ = 32,
  parameter int PRIO_BITS = 3,
  localparam int NEXC = 16 + N_IRQ,
  localparam int EXC_W = $clog2(NEXC),
  localparam int ADDR_W = EXC_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  src_fixed,
  input  logic [N_IRQ-1:0]  src_dma,
  input  logic [N_IRQ-1:0]  src_route,
  input  logic [15:0]       sys_req,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [EXC_W-1:0]  cfg_idx,
  input  logic [7:0]        cfg_wdata,
  output logic              irq_req,
  output logic [EXC_W-1:0]  irq_exc,
  output logic [ADDR_W-1:0] irq_addr,
  input  logic              cpu_ack,
  input  logic              cpu_ret
);
  import vint_pkg::*;

  logic [N_IRQ-1:0]               irq_en;
  logic [N_IRQ-1:0][1:0]          src_sel;
  logic [NEXC-1:0][PRIO_BITS-1:0] prio;
  logic [3:0]                     grp;
  logic [NEXC-1:0]                pend;
  logic [NEXC-1:0]                en_full;
  logic                           win_valid;
  logic [EXC_W-1:0]               win_exc;
  logic [LVL_W-1:0]               win_pre;
  logic [LVL_W-1:0]               act_lvl;
  logic [LVL_W-1:0]               req_lvl;
  logic                           ack_ok;
  logic                           ret_ok;
  logic                           may_preempt;

  assign en_full     = {irq_en, SYS_LIVE};
  assign ack_ok      = cpu_ack & irq_req;
  assign ret_ok      = cpu_ret & ~ack_ok;
  assign may_preempt = win_valid && (win_pre < act_lvl);

  vint_cfg #(.N_IRQ(N_IRQ), .PRIO_BITS(PRIO_BITS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .irq_en(irq_en),
    .src_sel(src_sel), .prio(prio), .grp(grp)
  );

  vint_pend #(.N_IRQ(N_IRQ)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_fixed(src_fixed), .src_dma(src_dma),
    .src_route(src_route), .src_sel(src_sel), .sys_req(sys_req),
    .clr_en(ack_ok), .clr_idx(irq_exc), .pend(pend)
  );

  vint_pick #(.N_IRQ(N_IRQ), .PRIO_BITS(PRIO_BITS)) u_pick (
    .pend(pend), .en_full(en_full), .prio(prio), .grp(grp),
    .win_valid(win_valid), .win_exc(win_exc), .win_pre(win_pre)
  );

  vint_lvl_stack #(.PRIO_BITS(PRIO_BITS)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(ack_ok), .pop(ret_ok),
    .push_lvl(req_lvl), .cur_lvl(act_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_exc <= '0;
      req_lvl <= LVL_IDLE;
    end else if (ack_ok) begin
      irq_req <= 1'b0;
    end else begin
      irq_req <= may_preempt;
      irq_exc <= win_exc;
      req_lvl <= win_pre;
    end
  end

  assign irq_addr = ADDR_W'(vec_addr(32'(irq_exc)));
endmodule

// File: rtl/vint_arbiter_chk.sv
module vint_arbiter_chk #(
  parameter int NEXC = 48,
  parameter int EXC_W = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       irq_req,
  input logic [EXC_W-1:0]           irq_exc,
  input logic                       ack_ok,
  input logic [vint_pkg::LVL_W-1:0] act_lvl,
  input logic [vint_pkg::LVL_W-1:0] req_lvl,
  input logic                       win_valid,
  input logic [EXC_W-1:0]           win_exc,
  input logic [NEXC-1:0]            pend,
  input logic [NEXC-1:0]            en_full
);
  p_req_preempts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (req_lvl < act_lvl));

  p_push_deeper_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ok |=> (act_lvl < $past(act_lvl)));

  p_ack_drops_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ok |=> !irq_req);

  p_no_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !(irq_exc inside {0, 1, 7, 8, 9, 10, 13}));

  p_win_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (pend[win_exc] && en_full[win_exc]));

  p_fixed_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend[2] |-> (win_valid && win_exc == EXC_W'(2)));
endmodule

bind vint_arbiter vint_arbiter_chk #(.NEXC(NEXC), .EXC_W(EXC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_exc(irq_exc),
  .ack_ok(ack_ok), .act_lvl(act_lvl), .req_lvl(req_lvl),
  .win_valid(win_valid), .win_exc(win_exc), .pend(pend), .en_full(en_full)
);

// File: tb/vint_arbiter_tb.sv
module vint_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_IRQ = 32;
  localparam int EXC_W = 6;

  logic              clk = 0;
  logic              rst_n = 0;
  logic [N_IRQ-1:0]  src_fixed = '0, src_dma = '0, src_route = '0;
  logic [15:0]       sys_req = '0;
  logic              cfg_we = 0;
  logic [1:0]        cfg_kind = '0;
  logic [EXC_W-1:0]  cfg_idx = '0;
  logic [7:0]        cfg_wdata = '0;
  logic              irq_req;
  logic [EXC_W-1:0]  irq_exc;
  logic [EXC_W+1:0]  irq_addr;
  logic              cpu_ack = 0, cpu_ret = 0;

  int tests = 0, fails = 0;
  bit done = 0;

  typedef struct { bit req; int exc; string tag; } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vint_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .src_fixed(src_fixed), .src_dma(src_dma),
    .src_route(src_route), .sys_req(sys_req), .cfg_we(cfg_we),
    .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .irq_req(irq_req), .irq_exc(irq_exc), .irq_addr(irq_addr),
    .cpu_ack(cpu_ack), .cpu_ret(cpu_ret)
  );

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      tests++;
      if (irq_req !== it.req) begin
        fails++;
        $display("FAIL %s: irq_req=%0b expected %0b", it.tag, irq_req, it.req);
      end else if (it.req && (int'(irq_exc) != it.exc || int'(irq_addr) != it.exc * 4)) begin
        fails++;
        $display("FAIL %s: exc=%0d addr=%0d expected exc=%0d addr=%0d",
                 it.tag, irq_exc, irq_addr, it.exc, it.exc * 4);
      end
    end
  end

  task automatic expect_now(bit r, int e, string tag);
    exp_t it;
    it.req = r; it.exc = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic check_next(bit r, int e, string tag);
    @(posedge clk); #1;
    expect_now(r, e, tag);
  endtask

  task automatic check_steady(bit r, int e, string tag);
    repeat (3) @(negedge clk);
    check_next(r, e, tag);
  endtask

  task automatic cfg_write(logic [1:0] k, int idx, int val);
    @(negedge clk);
    cfg_we = 1; cfg_kind = k; cfg_idx = EXC_W'(idx); cfg_wdata = 8'(val);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse(logic [N_IRQ-1:0] f, logic [N_IRQ-1:0] d,
                       logic [N_IRQ-1:0] r, logic [15:0] s);
    @(negedge clk);
    src_fixed = f; src_dma = d; src_route = r; sys_req = s;
    @(negedge clk);
    src_fixed = '0; src_dma = '0; src_route = '0; sys_req = '0;
  endtask

  task automatic do_ack();
    @(negedge clk); cpu_ack = 1;
    @(posedge clk); #1; cpu_ack = 0;
  endtask

  task automatic do_ret();
    @(negedge clk); cpu_ret = 1;
    @(negedge clk); cpu_ret = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run state=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    expect_now(0, 0, "R12 reset idle");
    tests++;
    if (irq_exc !== '0) begin
      fails++;
      $display("FAIL R12: irq_exc=%0d expected 0", irq_exc);
    end

    // R4 / R3: pending while disabled, offered once enabled
    pulse(32'h8, '0, '0, '0);
    check_steady(0, 0, "R4 disabled line not offered");
    cfg_write(2'd0, 19, 1);
    check_steady(1, 19, "R4 R3 R1 sticky pending offered after enable");

    // R11 / R3: acknowledge
    do_ack();
    expect_now(0, 0, "R11 ack drops request same edge");
    check_steady(0, 0, "R3 ack clears pending");
    do_ret();

    // R2 source selection
    cfg_write(2'd2, 21, 1);
    cfg_write(2'd0, 21, 1);
    pulse(32'h20, '0, '0, '0);
    check_steady(0, 0, "R2 fixed input ignored when DMA chosen");
    pulse('0, 32'h20, '0, '0);
    check_steady(1, 21, "R2 DMA input drives line");
    do_ack(); do_ret();
    cfg_write(2'd2, 21, 2);
    pulse('0, '0, 32'h20, '0);
    check_steady(1, 21, "R2 routed input drives line");
    do_ack(); do_ret();
    cfg_write(2'd2, 21, 3);
    pulse(32'h20, 32'h20, 32'h20, '0);
    check_steady(0, 0, "R2 code 3 selects nothing");

    // R6 tie, R8 rewrite, R10 nesting
    cfg_write(2'd0, 17, 1);
    cfg_write(2'd0, 18, 1);
    pulse(32'h6, '0, '0, '0);
    check_steady(1, 17, "R6 tie goes to lower number");
    cfg_write(2'd1, 17, 2);
    check_next(1, 18, "R8 new priority used next arbitration");
    do_ack();
    check_steady(0, 0, "R10 less urgent pending blocked");
    do_ret();
    check_steady(1, 17, "R10 return restores idle level");
    do_ack(); do_ret();

    // R7 grouping 0: full value preempts
    pulse(32'h2, '0, '0, '0);
    check_steady(1, 17, "R7 single line offered");
    do_ack();
    pulse(32'h4, '0, '0, '0);
    check_steady(1, 18, "R7 grouping 0 allows preemption");
    do_ack(); do_ret(); do_ret();
    check_steady(0, 0, "R10 all returned");

    // R7 grouping 2: same preempt level blocks
    cfg_write(2'd3, 0, 2);
    pulse(32'h2, '0, '0, '0);
    check_steady(1, 17, "R7 offered from idle");
    do_ack();
    pulse(32'h4, '0, '0, '0);
    check_steady(0, 0, "R7 subpriority cannot preempt");
    do_ret();
    check_steady(1, 18, "R7 released after return");
    do_ack(); do_ret();
    pulse(32'h6, '0, '0, '0);
    check_steady(1, 18, "R7 subpriority orders pending");
    do_ack();
    check_steady(0, 0, "R7 second line waits");
    do_ret();
    check_steady(1, 17, "R7 second line after return");
    do_ack(); do_ret();

    // R5 fixed levels
    pulse(32'h2, '0, '0, '0);
    check_steady(1, 17, "R5 setup");
    do_ack();
    pulse('0, '0, '0, 16'h000C);
    check_steady(1, 2, "R5 exception 2 wins over all");
    do_ack();
    check_steady(0, 0, "R5 exception 3 cannot preempt 2");
    do_ret();
    check_steady(1, 3, "R5 exception 3 preempts programmable");
    do_ack(); do_ret(); do_ret();

    // R9 reserved requests
    pulse('0, '0, '0, 16'h2783);
    check_steady(0, 0, "R9 reserved bits ignored");
    pulse('0, '0, '0, 16'h8000);
    check_steady(1, 15, "R9 live system exception 15");
    do_ack(); do_ret();

    // R10 spare return, R1 top line
    do_ret();
    cfg_write(2'd0, 47, 1);
    pulse(32'h8000_0000, '0, '0, '0);
    check_steady(1, 47, "R1 line 31 is exception 47");
    do_ack(); do_ret();
    check_steady(0, 0, "R10 idle at end");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule